// File: doc/BRIEF.md
# Parallel Bit Extract and Deposit Unit

This block compresses and expands bit fields in a word of `W` bits (64 by default). Extract collects the data bits picked out by a mask and packs them at the low end of the result. The bits keep their relative order and all higher result bits are zero. Deposit does the reverse. It takes the low-order bits of the data and spreads them, in order, onto the mask-selected positions, and clears every other bit.

Extract runs the data through an inverse butterfly network (distance 1 first, distance W/2 last) and then masks the result. Deposit runs the same switch settings through a butterfly network, with the stages applied in the opposite order, and then masks the result.

Each operation can be issued in one of two modes:

- **Fixed mode** uses switch settings already held in a local control bank. The result appears one cycle after the operation is accepted.
- **Decoding mode** first derives the switch settings from the mask. The result appears three cycles after acceptance. The derivation uses popcounts of the mask halves in every subnetwork and a running rotation passed down from the root. A decoding-mode operation can optionally write its settings into the control bank, so that later fixed-mode operations with the same mask run at the fast rate.

Operations enter through a valid/ready handshake. The block never holds more than one operation at a time.

Top module: `bitfield_pack_unit`

## Requirements
- R1: In extract mode (`op_sel`=0) the result holds, at bits 0..c-1, the mask-selected data bits in ascending position order, where c is the popcount of the mask. Bits c and above are zero.
- R2: In deposit mode (`op_sel`=1), data bit j (j < c) appears at the j-th lowest set position of the mask. Every result bit whose mask bit is 0 is zero.
- R3: A zero mask yields a zero result, and an all-ones mask returns the data unchanged, in both modes.
- R4: An operation accepted with `decode_sel`=1 raises `res_valid` exactly three cycles after acceptance. `req_ready` stays low in the cycles between acceptance and that result.
- R5: An operation accepted with `decode_sel`=0 raises `res_valid` one cycle after acceptance. `req_ready` stays high, so fixed-mode operations can be issued on consecutive cycles.
- R6: A decoding-mode operation issued with `keep_ctl`=1 loads its switch settings into the control bank. A later fixed-mode extract or deposit with the same mask then gives the R1/R2 result.
- R7: A decoding-mode operation with `keep_ctl`=0 leaves the control bank untouched. A fixed-mode operation afterwards still gives correct results for the mask loaded earlier. `keep_ctl` has no effect in fixed mode.
- R8: After reset, `req_ready`=1, `res_valid`=0, and the control bank has every switch straight. A fixed-mode operation therefore returns `data & mask` for a mask whose ones are contiguous from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Unit can accept an operation |
| op_sel | input | 1 | 0 = extract, 1 = deposit |
| decode_sel | input | 1 | 1 = derive switch settings from the mask, 0 = use the stored bank |
| keep_ctl | input | 1 | In decoding mode, store the derived settings in the bank |
| data_in | input | W | Data operand |
| mask_in | input | W | Selection mask |
| res_valid | output | 1 | Result valid for one cycle |
| res_data | output | W | Result |

## Verification
The bench builds the unit with W=64, so the networks have six stages of 32 switches each. At that width the decoder's rotation arithmetic wraps at every level from pairs up to the full word. Masks with popcounts from 0 through 64 are reached by ANDing and ORing random words, together with alternating, sparse, dense and per-byte field masks. Extract and deposit results are compared against bit-serial reference functions.

// File: rtl/bitfield_pack_unit.sv
module bitfield_pack_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         op_sel,
  input  logic         decode_sel,
  input  logic         keep_ctl,
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] mask_in,
  output logic         res_valid,
  output logic [W-1:0] res_data
);
  localparam int LG   = $clog2(W);
  localparam int HALF = W / 2;
  localparam int CW   = HALF * LG;

  // Stage s (pair distance 2**s) owns bits [s*HALF +: HALF] of a control word.
  function automatic logic [W-1:0] low_fill(input logic [W-1:0] m);
    logic [W-1:0] y;
    y = '0;
    for (int i = 0; i < W; i++)
      if (m[i]) y = {y[W-2:0], 1'b1};
    return y;
  endfunction

  function automatic logic [W-1:0] route(input logic [W-1:0] x, input logic [CW-1:0] c,
                                         input logic inv);
    logic [W-1:0] y;
    logic b;
    int s, d, idx;
    y = x;
    for (int st = 0; st < LG; st++) begin
      s = inv ? st : LG - 1 - st;
      d = 1 << s;
      for (int a = 0; a < W; a++)
        if ((a & d) == 0) begin
          idx = (a >> (s + 1)) * d + (a % d);
          if (c[s*HALF+idx]) begin
            b = y[a]; y[a] = y[a+d]; y[a+d] = b;
          end
        end
    end
    return y;
  endfunction

  function automatic logic [CW-1:0] decode(input logic [W-1:0] m);
    logic [CW-1:0] c;
    int cnt [LG+1][W];
    int rot [LG+1][W];
    int h, sz, k, r, t, v;
    c = '0;
    for (int i = 0; i < W; i++) begin
      cnt[0][i] = m[i] ? 1 : 0;
      rot[0][i] = 0;
    end
    for (int l = 1; l <= LG; l++)
      for (int n = 0; n < (W >> l); n++)
        cnt[l][n] = cnt[l-1][2*n] + cnt[l-1][2*n+1];
    rot[LG][0] = 0;
    for (int l = LG; l >= 1; l--) begin
      h  = 1 << (l - 1);
      sz = 1 << l;
      for (int n = 0; n < (W >> l); n++) begin
        k = cnt[l-1][2*n];
        r = rot[l][n];
        rot[l-1][2*n]   = r % h;
        rot[l-1][2*n+1] = (r + k) % h;
        for (int p = 0; p < h; p++) begin
          t = ((p - r) % h + h) % h;
          v = ((p - r) % sz + sz) % sz;
          c[(l-1)*HALF + n*h + p] = (v < h) ^ (t < k);
        end
      end
    end
    return c;
  endfunction

  logic          v1, v2;
  logic          op_q, keep_q;
  logic [W-1:0]  data_q, mask_q;
  logic [CW-1:0] bank_q, dec_q;
  logic          o_op;
  logic [W-1:0]  o_mask;

  wire take     = req_valid & req_ready;
  wire take_fix = take & ~decode_sel;
  wire take_dec = take & decode_sel;
  wire finish   = take_fix | v2;

  assign req_ready = ~(v1 | v2);

  wire           s_op   = v2 ? op_q   : op_sel;
  wire [W-1:0]   s_data = v2 ? data_q : data_in;
  wire [W-1:0]   s_mask = v2 ? mask_q : mask_in;
  wire [CW-1:0]  s_ctl  = v2 ? dec_q  : bank_q;

  wire [W-1:0] result = s_op ? (route(s_data, s_ctl, 1'b0) & s_mask)
                             : (route(s_data, s_ctl, 1'b1) & low_fill(s_mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      bank_q    <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      o_op      <= 1'b0;
      o_mask    <= '0;
    end else begin
      v1        <= take_dec;
      v2        <= v1;
      res_valid <= finish;
      if (take_dec) begin
        op_q   <= op_sel;
        keep_q <= keep_ctl;
        data_q <= data_in;
        mask_q <= mask_in;
      end
      if (v1) dec_q <= decode(mask_q);
      if (v2 && keep_q) bank_q <= dec_q;
      if (finish) begin
        res_data <= result;
        o_op     <= s_op;
        o_mask   <= s_mask;
      end
    end
  end

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_dec |=> !req_ready);
  p_dec_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_dec |-> ##3 res_valid);
  p_dec_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_dec |=> !res_valid);
  p_fix_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_fix |=> res_valid);
  p_dep_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && o_op) |-> ((res_data & ~o_mask) == '0));
  p_ext_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !o_op) |-> ($countones(res_data) <= $countones(o_mask)));
endmodule

// File: tb/bitfield_pack_unit_test.sv
`timescale 1ns/1ps
module bitfield_pack_unit_test;
  localparam int W = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, op_sel = 1'b0, decode_sel = 1'b0, keep_ctl = 1'b0;
  logic [W-1:0] data_in = '0, mask_in = '0;
  logic req_ready, res_valid;
  logic [W-1:0] res_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitfield_pack_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .op_sel(op_sel), .decode_sel(decode_sel), .keep_ctl(keep_ctl),
    .data_in(data_in), .mask_in(mask_in), .res_valid(res_valid), .res_data(res_data));

  function automatic logic [W-1:0] ref_ext(input logic [W-1:0] x, input logic [W-1:0] m);
    logic [W-1:0] r; int j;
    r = '0; j = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[j] = x[i]; j++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_dep(input logic [W-1:0] x, input logic [W-1:0] m);
    logic [W-1:0] r; int j;
    r = '0; j = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[i] = x[j]; j++; end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic op, input logic dec, input logic keep,
                     input logic [W-1:0] d, input logic [W-1:0] m,
                     output logic [W-1:0] res, output int lat);
    @(negedge clk);
    req_valid = 1'b1; op_sel = op; decode_sel = dec; keep_ctl = keep;
    data_in = d; mask_in = m;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (dec) check("R4 ready low while busy", {63'd0, req_ready}, '0);
    while (!res_valid && lat < 20) begin
      @(negedge clk);
      lat++;
      if (!res_valid && dec) check("R4 ready low while busy", {63'd0, req_ready}, '0);
    end
    res = res_data;
  endtask

  task automatic op_check(input string req, input logic op, input logic dec, input logic keep,
                          input logic [W-1:0] d, input logic [W-1:0] m);
    logic [W-1:0] r; int lat;
    run(op, dec, keep, d, m, r, lat);
    check(dec ? "R4 latency" : "R5 latency", W'(lat), dec ? W'(3) : W'(1));
    check(req, r, op ? ref_dep(d, m) : ref_ext(d, m));
  endtask

  function automatic logic [W-1:0] rmask(input int kind);
    logic [W-1:0] a, b;
    a = {$urandom, $urandom}; b = {$urandom, $urandom};
    case (kind)
      0: return a & b;
      1: return a | b;
      2: return a & b & {$urandom, $urandom};
      default: return a;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, d, m, ma;
    int lat;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 ready after reset", {63'd0, req_ready}, W'(1));
    check("R8 valid after reset", {63'd0, res_valid}, '0);
    d = 64'hDEAD_BEEF_0123_4567;
    run(1'b0, 1'b0, 1'b0, d, 64'h0FFF, r, lat);
    check("R8 straight bank extract", r, d & 64'h0FFF);
    run(1'b1, 1'b0, 1'b0, d, 64'h0000_FFFF_FFFF, r, lat);
    check("R8 straight bank deposit", r, d & 64'h0000_FFFF_FFFF);

    // R3 corner masks
    for (int op = 0; op < 2; op++) begin
      run(op[0], 1'b1, 1'b0, d, '0, r, lat);
      check("R3 zero mask", r, '0);
      run(op[0], 1'b1, 1'b0, d, '1, r, lat);
      check("R3 full mask", r, d);
    end

    // R1 nucleotide packing: bits 2 and 1 of each byte of "ATTCGCAC"
    op_check("R1 base pack", 1'b0, 1'b1, 1'b0, 64'h4154_5443_4743_4143, 64'h0606_0606_0606_0606);
    op_check("R1 alternating", 1'b0, 1'b1, 1'b0, 64'hF0F0_1234_5678_9ABC, 64'hAAAA_AAAA_AAAA_AAAA);
    op_check("R2 alternating", 1'b1, 1'b1, 1'b0, 64'hF0F0_1234_5678_9ABC, 64'h5555_5555_5555_5555);
    op_check("R2 top bit", 1'b1, 1'b1, 1'b0, 64'h1, 64'h8000_0000_0000_0000);
    op_check("R1 top bit", 1'b0, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001);

    // random decoding-mode traffic
    for (int i = 0; i < 400; i++) begin
      d = {$urandom, $urandom}; m = rmask(i % 4);
      op_check(i[0] ? "R2 random" : "R1 random", i[0], 1'b1, 1'b0, d, m);
    end

    // R6 bank load then fixed-mode reuse, R7 bank untouched by keep_ctl=0
    for (int i = 0; i < 60; i++) begin
      ma = rmask(i % 4);
      op_check("R6 loading op", 1'b0, 1'b1, 1'b1, {$urandom, $urandom}, ma);
      op_check("R6 fixed extract", 1'b0, 1'b0, 1'b0, {$urandom, $urandom}, ma);
      op_check("R6 fixed deposit", 1'b1, 1'b0, 1'b1, {$urandom, $urandom}, ma);
      op_check("R7 non-loading op", i[0], 1'b1, 1'b0, {$urandom, $urandom}, rmask(3));
      op_check("R7 bank kept", 1'b0, 1'b0, 1'b0, {$urandom, $urandom}, ma);
    end

    // R5 back-to-back fixed-mode issue
    ma = 64'h00FF_0F0F_3333_5555;
    op_check("R6 loading op", 1'b1, 1'b1, 1'b1, 64'h0, ma);
    @(negedge clk);
    req_valid = 1'b1; op_sel = 1'b0; decode_sel = 1'b0; keep_ctl = 1'b0;
    data_in = 64'h1111_2222_3333_4444; mask_in = ma;
    @(negedge clk);
    check("R5 ready stays high", {63'd0, req_ready}, W'(1));
    check("R5 first result valid", {63'd0, res_valid}, W'(1));
    check("R5 first result", res_data, ref_ext(64'h1111_2222_3333_4444, ma));
    op_sel = 1'b1; data_in = 64'hCAFE_F00D_8765_4321;
    @(negedge clk);
    req_valid = 1'b0;
    check("R5 second result valid", {63'd0, res_valid}, W'(1));
    check("R5 second result", res_data, ref_dep(64'hCAFE_F00D_8765_4321, ma));
    @(negedge clk);
    check("R5 valid drops", {63'd0, res_valid}, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule